// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a CPU bus and watches every bus cycle. Each of its channels holds a compare address, a per-bit address mask and a cycle-condition byte. When a bus cycle matches the settings of any channel, the block raises a one-cycle break request. It also sets that channel's sticky match flag. The condition byte names the bus, the kind of cycle (instruction fetch or data access), the direction and the operand size.

A breakpoint on an instruction fetch can fire before the instruction runs or after it. Before-execution breaks, like all data-access breaks, fire one cycle after the matching bus cycle. An after-execution break is held pending and fires one cycle after the core reports that the instruction executed. A flush of the fetched instruction drops the pending break.

The observed bus is a qualified stream. A cycle counts only while `bus_valid` is high. The monitor takes every cycle offered and never stalls the bus, so there is no back-pressure and no ready signal. The registers are programmed through a plain write port.

Top module: `bus_break_unit`

## Requirements
- R1: An address bit whose mask bit is 1 is left out of the comparison, and every other bit must equal the compare address. A mask of 0x00000FFF on base 0x8404 matches 0x8000 through 0x8FFE but not 0x7FFE or 0x9000. A mask of 0x006 on base 0x8010 matches 0x8016 but not 0x8011 or 0x8018. A mask of 0 needs all 32 bits to be equal.
- R2: The condition byte is laid out as follows. Bits [7:6] must equal `bus_sel`, and the CPU bus is 01. Bit 4 allows fetches and bit 5 allows data accesses. Bit 2 allows reads and bit 3 allows writes. Bits [1:0] hold the size. So 0x54 means fetch and read, 0x64 means data and read, and 0x6A means data, write and word. A channel whose kind bits or direction bits are 00 never matches, and a wrong bus select never matches.
- R3: Size field 00 matches any size. Otherwise the field must equal `bus_size`, where 01 is byte, 10 is word and 11 is longword. A word-write channel ignores byte writes and longword writes.
- R4: A data-access match, or a fetch match on a channel set to fire before execution, drives `break_req` high for exactly the one cycle after the bus cycle.
- R5: Control register bit 5 makes channel 0's fetch breaks fire after execution, and bit 4 does the same for channel 1. So 0x20 sets channel 0 to after-execution and leaves channel 1 before-execution. An after-execution match gives no break in the next cycle. The break comes in the cycle after `exec_strobe`.
- R6: A `flush` drops a pending after-execution break. This includes a `flush` in the same cycle as `exec_strobe`, and no break follows.
- R7: `break_req` is the OR of all channels, and both flags are set when both channels match in the same cycle.
- R8: A match flag stays set until a write to index 9 that has a 1 in the flag's bit position (bit 0 for channel 0, bit 1 for channel 1). Clearing one flag leaves the other flag as it was. A new match in the same cycle as the clear keeps the flag set.
- R9: Register writes take effect in the cycle after the write. The register indices are: channel c address at 4c, mask at 4c+1, condition at 4c+2, control at 8. A bus cycle in the same cycle as a write is judged with the old settings.
- R10: After reset every register is zero, so no channel matches, and `break_req` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this cycle |
| bus_sel | input | 2 | Bus the cycle runs on (01 = CPU bus) |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| bus_addr | input | 32 | Bus address |
| exec_strobe | input | 1 | The pending fetched instruction has executed |
| flush | input | 1 | The pending fetched instruction was discarded |
| break_req | output | 1 | Break request pulse |
| match_flag | output | 2 | Sticky per-channel match flags |

## Verification
Two functions can land in the same cycle: a register write and a bus cycle that is judged against that register. The bench drives a write of a new compare address at the same edge as a fetch from the old address. It expects a break from the old address and none from it afterwards. A second collision is a flag clear that arrives with a fresh match on the same channel. The bench expects the flag to stay set. A third is `exec_strobe` arriving with `flush`, after which the bench expects no break.

// File: rtl/bbu_pkg.sv
`timescale 1ns/1ps
package bbu_pkg;

  typedef struct packed {
    logic [1:0] sel;   // bus select
    logic [1:0] kind;  // [1]=data allowed, [0]=fetch allowed
    logic [1:0] dir;   // [1]=write allowed, [0]=read allowed
    logic [1:0] size;  // 00 any, 01 byte, 10 word, 11 long
  } cond_t;

  localparam logic [1:0] SIZE_ANY = 2'b00;
  localparam int unsigned COND_W  = $bits(cond_t);
  localparam int unsigned REGS_PER_CH = 4;

endpackage

// File: rtl/bbu_regs.sv
`timescale 1ns/1ps
module bbu_regs
  import bbu_pkg::*;
#(
  parameter int unsigned NCH       = 2,
  parameter int unsigned AW        = 32,
  parameter int unsigned RAW       = 4,
  parameter int unsigned POST_BIT0 = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [RAW-1:0]         addr_i,
  input  logic [AW-1:0]          wdata_i,
  output logic [NCH-1:0][AW-1:0] base_o,
  output logic [NCH-1:0][AW-1:0] mask_o,
  output cond_t [NCH-1:0]        cond_o,
  output logic [NCH-1:0]         post_o,
  output logic [NCH-1:0]         clr_o
);

  localparam logic [RAW-1:0] CTRL_IDX = RAW'(NCH * REGS_PER_CH);
  localparam logic [RAW-1:0] CLR_IDX  = RAW'(NCH * REGS_PER_CH + 1);

  // write-one-to-clear strobes for the sticky flags
  always_comb begin
    clr_o = '0;
    if (we_i && addr_i == CLR_IDX) clr_o = wdata_i[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [RAW-1:0] A_IDX = RAW'(c * REGS_PER_CH);
    localparam logic [RAW-1:0] M_IDX = RAW'(c * REGS_PER_CH + 1);
    localparam logic [RAW-1:0] C_IDX = RAW'(c * REGS_PER_CH + 2);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_o[c] <= '0;
        mask_o[c] <= '0;
        cond_o[c] <= '0;
        post_o[c] <= 1'b0;
      end else if (we_i) begin
        if (addr_i == A_IDX)    base_o[c] <= wdata_i;
        if (addr_i == M_IDX)    mask_o[c] <= wdata_i;
        if (addr_i == C_IDX)    cond_o[c] <= cond_t'(wdata_i[COND_W-1:0]);
        if (addr_i == CTRL_IDX) post_o[c] <= wdata_i[POST_BIT0 - c];
      end
    end

    // condition byte visible exactly one cycle after its write
    assert_cond_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == C_IDX) |=> (cond_o[c] == $past(wdata_i[COND_W-1:0])));

    assert_base_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == A_IDX) |=> (base_o[c] == $past(wdata_i)));
  end

endmodule

// File: rtl/bbu_match.sv
`timescale 1ns/1ps
module bbu_match
  import bbu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          valid_i,
  input  logic [1:0]    sel_i,
  input  logic          fetch_i,
  input  logic          write_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  cond_t         cond_i,
  output logic          hit_o
);

  logic addr_ok, bus_ok, kind_ok, dir_ok, size_ok;

  always_comb begin
    addr_ok = (((addr_i ^ base_i) & ~mask_i) == '0);
    bus_ok  = (cond_i.sel == sel_i);
    kind_ok = fetch_i ? cond_i.kind[0] : cond_i.kind[1];
    dir_ok  = write_i ? cond_i.dir[1]  : cond_i.dir[0];
    size_ok = (cond_i.size == SIZE_ANY) || (cond_i.size == size_i);
    hit_o   = valid_i && addr_ok && bus_ok && kind_ok && dir_ok && size_ok;
  end

endmodule

// File: rtl/bbu_fire.sv
`timescale 1ns/1ps
module bbu_fire (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic fetch_i,
  input  logic post_i,
  input  logic exec_i,
  input  logic flush_i,
  input  logic clr_i,
  output logic fire_o,
  output logic flag_o
);

  logic arm, now_fire, exec_fire, fire_next;
  logic pending_q;

  always_comb begin
    arm       = hit_i && post_i && fetch_i;
    now_fire  = hit_i && !(post_i && fetch_i);
    exec_fire = pending_q && exec_i && !flush_i;
    fire_next = now_fire || exec_fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      fire_o    <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      fire_o <= fire_next;
      if (arm)                     pending_q <= 1'b1;
      else if (flush_i || exec_i)  pending_q <= 1'b0;
      if (fire_next)               flag_o <= 1'b1;
      else if (clr_i)              flag_o <= 1'b0;
    end
  end

  // a flush with no new fetch leaves nothing pending
  assert_flush_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !arm) |=> !pending_q);

  // an after-execution fetch hit never fires on the next edge by itself
  assert_post_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !(pending_q && exec_i)) |=> !fire_o);

  // flag holds unless a clear is requested
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/bus_break_unit.sv
`timescale 1ns/1ps
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int unsigned NCH       = 2,
  parameter int unsigned AW        = 32,
  parameter int unsigned POST_BIT0 = 5,
  localparam int unsigned RAW      = $clog2(NCH * REGS_PER_CH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  input  logic           bus_valid,
  input  logic [1:0]     bus_sel,
  input  logic           bus_fetch,
  input  logic           bus_write,
  input  logic [1:0]     bus_size,
  input  logic [AW-1:0]  bus_addr,
  input  logic           exec_strobe,
  input  logic           flush,
  output logic           break_req,
  output logic [NCH-1:0] match_flag
);

  logic [NCH-1:0][AW-1:0] base, mask;
  cond_t [NCH-1:0]        cond;
  logic [NCH-1:0]         post, clr, hit, fire;

  bbu_regs #(.NCH(NCH), .AW(AW), .RAW(RAW), .POST_BIT0(POST_BIT0)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .base_o  (base),
    .mask_o  (mask),
    .cond_o  (cond),
    .post_o  (post),
    .clr_o   (clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bbu_match #(.AW(AW)) match_i (
      .valid_i (bus_valid),
      .sel_i   (bus_sel),
      .fetch_i (bus_fetch),
      .write_i (bus_write),
      .size_i  (bus_size),
      .addr_i  (bus_addr),
      .base_i  (base[c]),
      .mask_i  (mask[c]),
      .cond_i  (cond[c]),
      .hit_o   (hit[c])
    );

    bbu_fire fire_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit[c]),
      .fetch_i (bus_fetch),
      .post_i  (post[c]),
      .exec_i  (exec_strobe),
      .flush_i (flush),
      .clr_i   (clr[c]),
      .fire_o  (fire[c]),
      .flag_o  (match_flag[c])
    );

    // a channel with no kind or no direction enabled stays silent
    assert_disabled_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[c].kind == 2'b00 || cond[c].dir == 2'b00) |-> !hit[c]);
  end

  assign break_req = |fire;

  // every break stems from a bus cycle or an executed strobe one cycle earlier
  assert_break_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |-> ($past(bus_valid) || $past(exec_strobe)));

  // a break always leaves at least one flag set
  assert_break_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |-> (match_flag != '0));

  // reset leaves no break pending on the output
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> !break_req);

endmodule

// File: tb/bus_break_unit_tb.sv
`timescale 1ns/1ps
module bus_break_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_sel = 2'b01;
  logic        bus_fetch = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'b11;
  logic [31:0] bus_addr = '0;
  logic        exec_strobe = 1'b0;
  logic        flush = 1'b0;
  logic        break_req;
  logic [1:0]  match_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_break_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_valid(bus_valid), .bus_sel(bus_sel),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .exec_strobe(exec_strobe), .flush(flush),
    .break_req(break_req), .match_flag(match_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] data);
    reg_we = 1'b1; reg_addr = idx; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_bus(logic [1:0] sel, logic f, logic w, logic [1:0] sz, logic [31:0] a);
    bus_valid = 1'b1; bus_sel = sel; bus_fetch = f; bus_write = w;
    bus_size = sz; bus_addr = a;
  endtask

  task automatic cyc(logic [1:0] sel, logic f, logic w, logic [1:0] sz, logic [31:0] a);
    set_bus(sel, f, w, sz, a);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic clear_all();
    wr(4'd9, 32'h3);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // expect a break (and the given flags) one cycle after a fetch/data cycle
  task automatic probe(string tag, logic [1:0] sel, logic f, logic w, logic [1:0] sz,
                       logic [31:0] a, logic exp_brk);
    cyc(sel, f, w, sz, a);
    chk(tag, break_req, exp_brk);
    clear_all();
  endtask

  task automatic t_reset();
    chk("R10 reset break_req", break_req, 0);
    chk("R10 reset flags", match_flag, 0);
    probe("R10 zero config never matches", 2'b01, 1'b1, 1'b0, 2'b11, 32'h0, 1'b0);
  endtask

  task automatic t_mask_range();
    wr(4'd8, 32'h0);
    wr(4'd0, 32'h8404); wr(4'd1, 32'hFFF); wr(4'd2, 32'h54);
    probe("R1 low end 8000",  2'b01, 1'b1, 1'b0, 2'b11, 32'h8000, 1'b1);
    probe("R1 high end 8FFE", 2'b01, 1'b1, 1'b0, 2'b11, 32'h8FFE, 1'b1);
    probe("R1 above 9000",    2'b01, 1'b1, 1'b0, 2'b11, 32'h9000, 1'b0);
    probe("R1 below 7FFE",    2'b01, 1'b1, 1'b0, 2'b11, 32'h7FFE, 1'b0);
    wr(4'd2, 32'h0);
    wr(4'd4, 32'h8010); wr(4'd5, 32'h6); wr(4'd6, 32'h54);
    probe("R1 sparse 8016", 2'b01, 1'b1, 1'b0, 2'b11, 32'h8016, 1'b1);
    probe("R1 sparse 8011", 2'b01, 1'b1, 1'b0, 2'b11, 32'h8011, 1'b0);
    probe("R1 sparse 8018", 2'b01, 1'b1, 1'b0, 2'b11, 32'h8018, 1'b0);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_exact_data();
    wr(4'd0, 32'h123456); wr(4'd1, 32'h0); wr(4'd2, 32'h64);
    probe("R3 any size byte read", 2'b01, 1'b0, 1'b0, 2'b01, 32'h123456, 1'b1);
    probe("R3 any size word read", 2'b01, 1'b0, 1'b0, 2'b10, 32'h123456, 1'b1);
    probe("R3 any size long read", 2'b01, 1'b0, 1'b0, 2'b11, 32'h123456, 1'b1);
    probe("R1 exact off by one",   2'b01, 1'b0, 1'b0, 2'b11, 32'h123457, 1'b0);
    probe("R2 fetch on data chan", 2'b01, 1'b1, 1'b0, 2'b11, 32'h123456, 1'b0);
    probe("R2 write on read chan", 2'b01, 1'b0, 1'b1, 2'b11, 32'h123456, 1'b0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_size();
    wr(4'd4, 32'hABCDE); wr(4'd5, 32'hFF); wr(4'd6, 32'h6A);
    probe("R3 word write ABC00", 2'b01, 1'b0, 1'b1, 2'b10, 32'hABC00, 1'b1);
    probe("R3 word write ABCFE", 2'b01, 1'b0, 1'b1, 2'b10, 32'hABCFE, 1'b1);
    probe("R3 byte write",       2'b01, 1'b0, 1'b1, 2'b01, 32'hABC10, 1'b0);
    probe("R3 long write",       2'b01, 1'b0, 1'b1, 2'b11, 32'hABC10, 1'b0);
    probe("R3 word read",        2'b01, 1'b0, 1'b0, 2'b10, 32'hABC10, 1'b0);
    probe("R1 word write ABD00", 2'b01, 1'b0, 1'b1, 2'b10, 32'hABD00, 1'b0);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_cond_fields();
    wr(4'd0, 32'h500); wr(4'd1, 32'h0); wr(4'd2, 32'h54);
    probe("R2 wrong bus select", 2'b10, 1'b1, 1'b0, 2'b11, 32'h500, 1'b0);
    wr(4'd2, 32'h44);
    probe("R2 kind 00 silent",   2'b01, 1'b1, 1'b0, 2'b11, 32'h500, 1'b0);
    wr(4'd2, 32'h50);
    probe("R2 dir 00 silent",    2'b01, 1'b1, 1'b0, 2'b11, 32'h500, 1'b0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_post_exec();
    wr(4'd8, 32'h20);
    wr(4'd0, 32'h100); wr(4'd1, 32'h0); wr(4'd2, 32'h54);
    cyc(2'b01, 1'b1, 1'b0, 2'b11, 32'h100);
    chk("R5 no break before exec", break_req, 0);
    chk("R5 no flag before exec", match_flag, 0);
    idle(2);
    exec_strobe = 1'b1; @(negedge clk); exec_strobe = 1'b0;
    chk("R5 break after exec", break_req, 1);
    chk("R5 flag0 after exec", match_flag, 2'b01);
    @(negedge clk);
    chk("R4 single cycle pulse", break_req, 0);
    clear_all();
    wr(4'd2, 32'h0);
    wr(4'd4, 32'h200); wr(4'd5, 32'h0); wr(4'd6, 32'h54);
    probe("R5 ch1 stays pre-exec", 2'b01, 1'b1, 1'b0, 2'b11, 32'h200, 1'b1);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_flush();
    wr(4'd8, 32'h20);
    wr(4'd0, 32'h100); wr(4'd1, 32'h0); wr(4'd2, 32'h54);
    cyc(2'b01, 1'b1, 1'b0, 2'b11, 32'h100);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    exec_strobe = 1'b1; @(negedge clk); exec_strobe = 1'b0;
    chk("R6 flush then exec no break", break_req, 0);
    cyc(2'b01, 1'b1, 1'b0, 2'b11, 32'h100);
    exec_strobe = 1'b1; flush = 1'b1; @(negedge clk);
    exec_strobe = 1'b0; flush = 1'b0;
    chk("R6 exec with flush no break", break_req, 0);
    exec_strobe = 1'b1; @(negedge clk); exec_strobe = 1'b0;
    chk("R6 nothing left pending", break_req, 0);
    chk("R6 no flag", match_flag, 0);
    wr(4'd2, 32'h0); wr(4'd8, 32'h0);
  endtask

  task automatic t_or_and_flags();
    wr(4'd0, 32'h700); wr(4'd1, 32'h0); wr(4'd2, 32'h54);
    wr(4'd4, 32'h700); wr(4'd5, 32'h0); wr(4'd6, 32'h54);
    cyc(2'b01, 1'b1, 1'b0, 2'b11, 32'h700);
    chk("R7 both channels break", break_req, 1);
    chk("R7 both flags", match_flag, 2'b11);
    idle(3);
    chk("R8 flags sticky", match_flag, 2'b11);
    wr(4'd9, 32'h2);
    chk("R8 clear ch1 only", match_flag, 2'b01);
    wr(4'd6, 32'h0);
    // clear of ch0 coincides with a new ch0 hit
    reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 32'h1;
    set_bus(2'b01, 1'b1, 1'b0, 2'b11, 32'h700);
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    chk("R8 set beats clear", match_flag, 2'b01);
    clear_all();
    chk("R8 cleared", match_flag, 2'b00);
    wr(4'd2, 32'h0);
    wr(4'd4, 32'h710); wr(4'd6, 32'h54);
    probe("R7 ch1 alone breaks", 2'b01, 1'b1, 1'b0, 2'b11, 32'h710, 1'b1);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_write_timing();
    wr(4'd8, 32'h0);
    wr(4'd0, 32'h300); wr(4'd1, 32'h0); wr(4'd2, 32'h54);
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h400;
    set_bus(2'b01, 1'b1, 1'b0, 2'b11, 32'h300);
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    chk("R9 same-cycle uses old base", break_req, 1);
    clear_all();
    probe("R9 new base matches", 2'b01, 1'b1, 1'b0, 2'b11, 32'h400, 1'b1);
    probe("R9 old base gone",    2'b01, 1'b1, 1'b0, 2'b11, 32'h300, 1'b0);
    reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h0;
    set_bus(2'b01, 1'b1, 1'b0, 2'b11, 32'h400);
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    chk("R9 same-cycle uses old cond", break_req, 1);
    clear_all();
    probe("R9 cond now off", 2'b01, 1'b1, 1'b0, 2'b11, 32'h400, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_range();
    t_exact_data();
    t_size();
    t_cond_fields();
    t_post_exec();
    t_flush();
    t_or_and_flags();
    t_write_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule